// File: doc/BRIEF.md
# DMA Width-Translation Stager

This block stands between the device side of a DMA engine, which moves one byte or one 16-bit word per transfer, and a 32-bit memory-side bus. It keeps one four-byte staging buffer.

For device-to-memory transfers, it collects incoming bytes or words into the buffer at the lane picked by the low address bits. It issues a single memory write with byte enables once one of these happens:
- the doubleword fills,
- a later transfer leaves the doubleword,
- the channel changes,
- the direction changes,
- terminal count arrives.

For memory-to-device transfers, it fetches a whole doubleword with one memory read and serves the following byte or word transfers from the buffer until one leaves that doubleword.

A memory cycle that ends in an abort completes like a normal one. Read data is then undefined, and nothing signals an error toward the device. The device acknowledge is withheld while a memory cycle is outstanding.

A separate pacer serves three motherboard-device request lines. It answers each with an active-low acknowledge pulse and keeps successive pulses a minimum number of clock periods apart.

Top module: `dma_xfer_stager`

## Requirements
- R1: While reset is applied and right after its release, `dev_ack` and `mem_req` are 0 and every bit of `mb_ack_n` is 1.
- R2: A device write places `dev_wdata[7:0]` at byte lane `dev_addr[1:0]`. A 16-bit write (`dev_word`=1) also places `dev_wdata[15:8]` at lane `dev_addr[1:0]`+1. When all four lanes are filled, the block issues one memory write with `mem_be`=4'b1111, with `mem_addr` equal to `dev_addr[ADDR_W-1:2]`, and with lane n carried on `mem_wdata[8n+7:8n]`.
- R3: A device write whose doubleword differs from the buffered one first causes a memory write of the buffered lanes. In that write, `mem_be` bit n is 1 only for filled lanes. The new data is accepted only after that write.
- R4: A device write with `dev_tc`=1 is acknowledged and then immediately flushed, with `mem_be` marking only the valid lanes.
- R5: A device read outside the buffered doubleword, or with no valid read data, causes one memory read (`mem_we`=0, `mem_be`=4'b1111). Further reads in that doubleword need no memory cycle. A byte read returns the lane on `dev_rdata[7:0]` with `dev_rdata[15:8]`=0. A word read returns {lane+1, lane}.
- R6: A device read with `dev_tc`=1 invalidates the read data after it is served, so the next read refetches even in the same doubleword.
- R7: A memory cycle ending in `mem_abort` is treated as complete. A pending device read is still acknowledged, with undefined data. Aborted write data is discarded, and later writes carry only their own lanes.
- R8: `dev_ack` is never 1 while `mem_req` is 1.
- R9: A request from a different channel (`dev_chan`) than the buffered one flushes pending write lanes first. For reads, it forces a refetch.
- R10: A read while write lanes are pending flushes them before reading. An accepted write invalidates buffered read data.
- R11: Once raised, `mem_req` stays 1 until `mem_done` or `mem_abort`. While it is held, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` remain stable.
- R12: Each `mb_ack_n` pulse is low for one cycle, at most one line is low at a time, and a line is acknowledged only if it was requesting. When several lines request, the lowest index wins. Pulse starts are `MIN_GAP` (3) cycles apart under continuous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 1 | Device transfer request, held until acknowledged |
| dev_wr | input | 1 | 1: device-to-memory, 0: memory-to-device |
| dev_word | input | 1 | 1: 16-bit transfer, 0: 8-bit transfer |
| dev_tc | input | 1 | Terminal count with this transfer |
| dev_chan | input | CH_W | Active channel number |
| dev_addr | input | ADDR_W | Byte address of the transfer |
| dev_wdata | input | 16 | Device write data |
| dev_ack | output | 1 | Transfer accepted this cycle |
| dev_rdata | output | 16 | Device read data, valid with dev_ack |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1: memory write, 0: memory read |
| mem_addr | output | ADDR_W-2 | Doubleword address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_done | input | 1 | Memory cycle completed normally |
| mem_abort | input | 1 | Memory cycle ended by an abort |
| mb_req | input | NCH | Motherboard-device DMA requests |
| mb_ack_n | output | NCH | Active-low motherboard-device acknowledges |

## Verification
The bench goes after the edges of the buffer:
- A partially filled doubleword left by an address step, a channel switch or a turn to reading must be written with only its filled lanes enabled. A design that got this wrong would lose bytes or write stale lanes.
- Reads hitting the buffered doubleword must cause no memory traffic. A terminal-count read or an intervening write must force a refetch; a design that kept stale read data would hand the device old bytes.
- After an abort on a read or a write, the device must still be released and the buffer left clean. A wrong design would hang the transfer, or would carry discarded lanes into the next write.
- For the pacer, the bench measures the spacing and owner of each acknowledge pulse. A pacer that miscounts would produce pulses one cycle early, or would grant a line that is not requesting.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_FILL  = 2'd2
  } stg_state_e;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/stg_lane_merge.sv
// Merges one byte or word from the device into the staging lanes.
module stg_lane_merge #(
  parameter int unsigned LANES = 4
) (
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic                     word,
  input  logic [15:0]              wdata,
  input  logic [8*LANES-1:0]       old_data,
  input  logic [LANES-1:0]         old_be,
  output logic [8*LANES-1:0]       new_data,
  output logic [LANES-1:0]         new_be
);
  localparam int unsigned LW = $clog2(LANES);

  logic [LW-1:0] hi_lane;
  assign hi_lane = lane + LW'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic sel_lo, sel_hi;
    assign sel_lo = (lane == LW'(g));
    assign sel_hi = word && (hi_lane == LW'(g));
    assign new_data[8*g +: 8] = sel_lo ? wdata[7:0] :
                                sel_hi ? wdata[15:8] : old_data[8*g +: 8];
    assign new_be[g] = old_be[g] | sel_lo | sel_hi;
  end
endmodule

// File: rtl/stg_lane_pick.sv
// Selects the byte or word the device reads out of the staging lanes.
module stg_lane_pick #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0]       data,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic                     word,
  output logic [15:0]              rdata
);
  localparam int unsigned LW = $clog2(LANES);

  logic [LW-1:0] hi_lane;
  logic [7:0]    lo_b, hi_b;

  assign hi_lane = lane + LW'(1);
  assign lo_b    = data[{lane, 3'b000} +: 8];
  assign hi_b    = data[{hi_lane, 3'b000} +: 8];
  assign rdata   = {word ? hi_b : 8'h00, lo_b};
endmodule

// File: rtl/stg_fast_pacer.sv
// Spaces acknowledge pulses on the motherboard-device request lines.
module stg_fast_pacer #(
  parameter int unsigned NCH     = 3,
  parameter int unsigned MIN_GAP = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] ack_n
);
  localparam int unsigned CW = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP);
  localparam logic [CW-1:0] RELOAD = CW'(MIN_GAP - 1);

  logic [NCH-1:0] ak_q, ak_d, pick;
  logic [CW-1:0]  cnt_q, cnt_d;

  assign pick = req & (~req + NCH'(1));

  always_comb begin
    ak_d  = '0;
    cnt_d = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end else if (|req) begin
      ak_d  = pick;
      cnt_d = RELOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ak_q  <= '0;
      cnt_q <= '0;
    end else begin
      ak_q  <= ak_d;
      cnt_q <= cnt_d;
    end
  end

  assign ack_n = ~ak_q;
endmodule

// File: rtl/dma_xfer_stager.sv
module dma_xfer_stager
  import stg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned CH_W    = 3,
  parameter int unsigned NCH     = 3,
  parameter int unsigned MIN_GAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_req,
  input  logic              dev_wr,
  input  logic              dev_word,
  input  logic              dev_tc,
  input  logic [CH_W-1:0]   dev_chan,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [15:0]       dev_wdata,
  output logic              dev_ack,
  output logic [15:0]       dev_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_done,
  input  logic              mem_abort,
  input  logic [NCH-1:0]    mb_req,
  output logic [NCH-1:0]    mb_ack_n
);
  localparam int unsigned DW_W = ADDR_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      srst_n  <= rs_meta;
    end
  end

  stg_state_e            st_q, st_d;
  logic [8*LANES-1:0]    buf_data_q, buf_data_d;
  logic [LANES-1:0]      buf_be_q, buf_be_d;
  logic [DW_W-1:0]       buf_dw_q;
  logic [CH_W-1:0]       buf_ch_q;
  logic                  buf_rd_q, buf_rd_d;
  logic                  data_en, be_en, tag_en, rd_en;

  logic [DW_W-1:0]       req_dw;
  logic [1:0]            lane;
  logic                  same_blk, need_flush, rd_hit, in_idle, mem_end;
  logic                  wr_take, rd_take, rd_miss;
  logic [8*LANES-1:0]    mrg_data;
  logic [LANES-1:0]      mrg_be;

  assign req_dw     = dev_addr[ADDR_W-1:2];
  assign lane       = dev_addr[1:0];
  assign in_idle    = (st_q == ST_IDLE);
  assign mem_end    = mem_done || mem_abort;
  assign same_blk   = (req_dw == buf_dw_q) && (dev_chan == buf_ch_q);
  assign need_flush = (|buf_be_q) && (!dev_wr || !same_blk);
  assign rd_hit     = buf_rd_q && same_blk;
  assign wr_take    = in_idle && dev_req && dev_wr && !need_flush;
  assign rd_take    = in_idle && dev_req && !dev_wr && !need_flush && rd_hit;
  assign rd_miss    = in_idle && dev_req && !dev_wr && !need_flush && !rd_hit;

  stg_lane_merge #(.LANES(LANES)) u_merge (
    .lane     (lane),
    .word     (dev_word),
    .wdata    (dev_wdata),
    .old_data (buf_data_q),
    .old_be   (buf_be_q),
    .new_data (mrg_data),
    .new_be   (mrg_be)
  );

  stg_lane_pick #(.LANES(LANES)) u_pick (
    .data  (buf_data_q),
    .lane  (lane),
    .word  (dev_word),
    .rdata (dev_rdata)
  );

  stg_fast_pacer #(.NCH(NCH), .MIN_GAP(MIN_GAP)) u_pacer (
    .clk   (clk),
    .rst_n (srst_n),
    .req   (mb_req),
    .ack_n (mb_ack_n)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (dev_req && need_flush)                  st_d = ST_FLUSH;
        else if (wr_take && ((&mrg_be) || dev_tc))  st_d = ST_FLUSH;
        else if (rd_miss)                           st_d = ST_FILL;
      end
      ST_FLUSH: if (mem_end) st_d = ST_IDLE;
      ST_FILL:  if (mem_end) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // buffer next values and enables
  always_comb begin
    data_en    = wr_take || ((st_q == ST_FILL) && mem_end);
    buf_data_d = wr_take ? mrg_data : mem_rdata;
    be_en      = wr_take || ((st_q == ST_FLUSH) && mem_end);
    buf_be_d   = wr_take ? mrg_be : '0;
    tag_en     = wr_take || rd_miss;
    rd_en      = wr_take || ((st_q == ST_FILL) && mem_end) || (rd_take && dev_tc);
    buf_rd_d   = (st_q == ST_FILL);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      buf_data_q <= '0;
      buf_be_q   <= '0;
      buf_dw_q   <= '0;
      buf_ch_q   <= '0;
      buf_rd_q   <= 1'b0;
    end else begin
      if (data_en) buf_data_q <= buf_data_d;
      if (be_en)   buf_be_q   <= buf_be_d;
      if (tag_en) begin
        buf_dw_q <= req_dw;
        buf_ch_q <= dev_chan;
      end
      if (rd_en)   buf_rd_q   <= buf_rd_d;
    end
  end

  assign dev_ack   = wr_take || rd_take;
  assign mem_req   = !in_idle;
  assign mem_we    = (st_q == ST_FLUSH);
  assign mem_addr  = buf_dw_q;
  assign mem_be    = (st_q == ST_FLUSH) ? buf_be_q : 4'hF;
  assign mem_wdata = buf_data_q;
endmodule

// File: rtl/stg_chk.sv
module stg_chk #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned NCH     = 3,
  parameter int unsigned MIN_GAP = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              mem_done,
  input logic              mem_abort,
  input logic [NCH-1:0]    mb_req,
  input logic [NCH-1:0]    mb_ack_n
);
  localparam int unsigned GW = $clog2(MIN_GAP + 1) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          any_ack;

  assign any_ack = |(~mb_ack_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (any_ack) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q < GW'(MIN_GAP)) begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  // R8
  ack_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !dev_ack);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done && !mem_abort) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) &&
       $stable(mem_be) && $stable(mem_wdata)));

  // R3
  wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

  // R5
  rd_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_be == 4'hF));

  // R12
  mb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mb_ack_n));

  // R12
  mb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ack && (MIN_GAP > 1)) |=> (&mb_ack_n));

  // R12
  mb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ack && seen_q) |-> (gap_q >= GW'(MIN_GAP - 1)));

  // R12
  mb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mb_ack_n) & ~$past(mb_req)) == '0);
endmodule

bind dma_xfer_stager stg_chk #(
  .ADDR_W (ADDR_W),
  .NCH    (NCH),
  .MIN_GAP(MIN_GAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_ack   (dev_ack),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .mem_done  (mem_done),
  .mem_abort (mem_abort),
  .mb_req    (mb_req),
  .mb_ack_n  (mb_ack_n)
);

// File: tb/sim_dma_xfer_stager.sv
module sim_dma_xfer_stager;
  localparam int CLK_P   = 10;
  localparam int ADDR_W  = 24;
  localparam int CH_W    = 3;
  localparam int NCH     = 3;
  localparam int MIN_GAP = 3;
  localparam int LAT     = 2;

  typedef struct packed {
    logic        we;
    logic [21:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } mexp_t;

  logic              clk, rst_n;
  logic              dev_req, dev_wr, dev_word, dev_tc;
  logic [CH_W-1:0]   dev_chan;
  logic [ADDR_W-1:0] dev_addr;
  logic [15:0]       dev_wdata;
  logic              dev_ack;
  logic [15:0]       dev_rdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              mem_done, mem_abort;
  logic [NCH-1:0]    mb_req, mb_ack_n;

  int    total, bad;
  bit    finished;
  bit    abort_next;
  mexp_t exq[$];

  dma_xfer_stager #(.ADDR_W(ADDR_W), .CH_W(CH_W), .NCH(NCH), .MIN_GAP(MIN_GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_wr(dev_wr),
    .dev_word(dev_word), .dev_tc(dev_tc), .dev_chan(dev_chan),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
    .dev_rdata(dev_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .mem_abort(mem_abort),
    .mb_req(mb_req), .mb_ack_n(mb_ack_n)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic logic [31:0] pat(input logic [21:0] a);
    return {~a[7:0], a[7:0] ^ 8'h5A, a[7:0] + 8'h11, a[7:0]};
  endfunction

  function automatic logic [15:0] rd_exp(input logic [23:0] a, input bit word);
    logic [31:0] d;
    logic [7:0]  lo, hi;
    d  = pat(a[23:2]);
    lo = d[{a[1:0], 3'b000} +: 8];
    hi = d[{a[1:0] + 2'd1, 3'b000} +: 8];
    return {word ? hi : 8'h00, lo};
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic push_wr(input logic [21:0] a, input logic [3:0] be, input logic [31:0] d);
    exq.push_back('{we: 1'b1, addr: a, be: be, data: d});
  endtask

  task automatic push_rd(input logic [21:0] a);
    exq.push_back('{we: 1'b0, addr: a, be: 4'hF, data: 32'h0});
  endtask

  // memory responder and scoreboard monitor
  initial begin
    mem_done  = 1'b0;
    mem_abort = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        mexp_t got, ex;
        bit    stable_ok;
        got = '{we: mem_we, addr: mem_addr, be: mem_be, data: mem_wdata};
        stable_ok = 1'b1;
        repeat (LAT) begin
          @(negedge clk);
          if (!mem_req || mem_we != got.we || mem_addr != got.addr ||
              mem_be != got.be || mem_wdata != got.data) stable_ok = 1'b0;
        end
        chk(stable_ok, "R11", "memory request held stable", {31'd0, stable_ok}, 32'd1);
        if (exq.size() == 0) begin
          chk(1'b0, "R5", "unexpected memory cycle addr", {10'd0, got.addr}, 32'hFFFFFFFF);
        end else begin
          ex = exq.pop_front();
          chk(got.we == ex.we, ex.we ? "R2" : "R5", "mem_we", {31'd0, got.we}, {31'd0, ex.we});
          chk(got.addr == ex.addr, ex.we ? "R3" : "R5", "mem_addr", {10'd0, got.addr}, {10'd0, ex.addr});
          chk(got.be == ex.be, ex.we ? "R3" : "R5", "mem_be", {28'd0, got.be}, {28'd0, ex.be});
          if (ex.we)
            chk((got.data & be_mask(ex.be)) == (ex.data & be_mask(ex.be)), "R2",
                "mem_wdata lanes", got.data & be_mask(ex.be), ex.data & be_mask(ex.be));
        end
        mem_rdata = pat(got.addr);
        if (abort_next) begin
          mem_abort  = 1'b1;
          abort_next = 1'b0;
        end else begin
          mem_done = 1'b1;
        end
        @(negedge clk);
        mem_done  = 1'b0;
        mem_abort = 1'b0;
      end
    end
  end

  task automatic dev_xfer(input bit wr, input bit word, input logic [23:0] a,
                          input logic [15:0] d, input bit tc, input logic [2:0] ch,
                          input bit rchk, input string req);
    int  w;
    bit  got;
    @(posedge clk); #1;
    dev_wr = wr; dev_word = word; dev_addr = a; dev_wdata = d;
    dev_tc = tc; dev_chan = ch; dev_req = 1'b1;
    w = 0; got = 1'b0;
    while (!got && w < 400) begin
      @(negedge clk);
      if (dev_ack && mem_req) chk(1'b0, "R8", "ack during memory cycle", 32'd1, 32'd0);
      if (dev_ack) got = 1'b1;
      w++;
    end
    chk(got, req, "device acknowledge received", {31'd0, got}, 32'd1);
    if (got && !wr && rchk)
      chk(dev_rdata == rd_exp(a, word), req, "dev_rdata", {16'd0, dev_rdata}, {16'd0, rd_exp(a, word)});
    @(posedge clk); #1;
    dev_req = 1'b0; dev_tc = 1'b0;
  endtask

  task automatic drain(input string req);
    int w;
    w = 0;
    while ((exq.size() != 0 || mem_req) && w < 400) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    chk(exq.size() == 0, req, "expected memory cycles all seen", exq.size(), 32'd0);
  endtask

  task automatic pacer_phase(input logic [2:0] r, input int cycles, input int idx,
                             input int exp_n);
    int last, n;
    last = -1; n = 0;
    @(posedge clk); #1;
    mb_req = r;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (mb_ack_n != 3'b111 && !(r == 3'b000 && c == 0)) begin
        chk(~mb_ack_n == (3'b001 << idx), "R12", "acknowledged line",
            {29'd0, ~mb_ack_n}, {29'd0, 3'b001 << idx});
        if (last >= 0)
          chk(c - last == MIN_GAP, "R12", "pulse spacing", c - last, MIN_GAP);
        last = c;
        n++;
      end
    end
    chk(n == exp_n, "R12", "pulse count", n, exp_n);
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "WATCHDOG", "run did not finish", 32'd0, 32'd1);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 1'b0; abort_next = 1'b0;
    rst_n = 1'b0; dev_req = 1'b0; dev_wr = 1'b0; dev_word = 1'b0; dev_tc = 1'b0;
    dev_chan = '0; dev_addr = '0; dev_wdata = '0; mb_req = '0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(!dev_ack && !mem_req && mb_ack_n == 3'b111, "R1", "outputs in reset",
        {dev_ack, mem_req, mb_ack_n}, {2'b00, 3'b111});
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!dev_ack && !mem_req && mb_ack_n == 3'b111, "R1", "outputs after reset",
        {dev_ack, mem_req, mb_ack_n}, {2'b00, 3'b111});

    // R2 byte packing
    dev_xfer(1, 0, 24'h000100, 16'h0011, 0, 0, 0, "R2");
    dev_xfer(1, 0, 24'h000101, 16'h0022, 0, 0, 0, "R2");
    dev_xfer(1, 0, 24'h000102, 16'h0033, 0, 0, 0, "R2");
    push_wr(22'h40, 4'hF, 32'h44332211);
    dev_xfer(1, 0, 24'h000103, 16'h0044, 0, 0, 0, "R2");
    drain("R2");

    // R2 word packing
    dev_xfer(1, 1, 24'h000204, 16'hBBAA, 0, 0, 0, "R2");
    push_wr(22'h81, 4'hF, 32'hDDCCBBAA);
    dev_xfer(1, 1, 24'h000206, 16'hDDCC, 0, 0, 0, "R2");
    drain("R2");

    // R3 partial flush on doubleword change, then R4 terminal count
    dev_xfer(1, 0, 24'h000301, 16'h005E, 0, 0, 0, "R3");
    push_wr(22'hC0, 4'b0010, 32'h00005E00);
    push_wr(22'hC2, 4'b0001, 32'h00000077);
    dev_xfer(1, 0, 24'h000308, 16'h0077, 1, 0, 0, "R4");
    drain("R3");

    // R4 word with terminal count in upper half
    push_wr(22'h102, 4'b1100, 32'h12340000);
    dev_xfer(1, 1, 24'h00040A, 16'h1234, 1, 0, 0, "R4");
    drain("R4");

    // R5 read fill and hits
    push_rd(22'h140);
    dev_xfer(0, 0, 24'h000500, 16'h0, 0, 0, 1, "R5");
    dev_xfer(0, 0, 24'h000501, 16'h0, 0, 0, 1, "R5");
    dev_xfer(0, 1, 24'h000502, 16'h0, 0, 0, 1, "R5");
    drain("R5");
    push_rd(22'h141);
    dev_xfer(0, 0, 24'h000504, 16'h0, 0, 0, 1, "R5");
    // R6 terminal count invalidates
    dev_xfer(0, 0, 24'h000505, 16'h0, 1, 0, 1, "R6");
    drain("R6");
    push_rd(22'h141);
    dev_xfer(0, 1, 24'h000506, 16'h0, 0, 0, 1, "R6");
    drain("R6");

    // R9 channel change on writes
    dev_xfer(1, 0, 24'h000600, 16'h00A1, 0, 0, 0, "R9");
    push_wr(22'h180, 4'b0001, 32'h000000A1);
    dev_xfer(1, 0, 24'h000601, 16'h00B2, 0, 1, 0, "R9");
    push_wr(22'h180, 4'b0110, 32'h00C3B200);
    dev_xfer(1, 0, 24'h000602, 16'h00C3, 1, 1, 0, "R9");
    drain("R9");
    // R9 channel change on reads
    push_rd(22'h1C0);
    dev_xfer(0, 0, 24'h000700, 16'h0, 0, 0, 1, "R9");
    push_rd(22'h1C0);
    dev_xfer(0, 0, 24'h000701, 16'h0, 0, 1, 1, "R9");
    drain("R9");

    // R10 direction change
    dev_xfer(1, 0, 24'h000800, 16'h009D, 0, 0, 0, "R10");
    push_wr(22'h200, 4'b0001, 32'h0000009D);
    push_rd(22'h200);
    dev_xfer(0, 0, 24'h000800, 16'h0, 0, 0, 1, "R10");
    push_wr(22'h200, 4'b0010, 32'h00004E00);
    dev_xfer(1, 0, 24'h000801, 16'h004E, 1, 0, 0, "R10");
    drain("R10");
    push_rd(22'h200);
    dev_xfer(0, 0, 24'h000802, 16'h0, 0, 0, 1, "R10");
    drain("R10");

    // R7 aborts
    abort_next = 1'b1;
    push_rd(22'h240);
    dev_xfer(0, 0, 24'h000900, 16'h0, 0, 0, 0, "R7");
    drain("R7");
    push_rd(22'h241);
    dev_xfer(0, 0, 24'h000904, 16'h0, 0, 0, 1, "R7");
    drain("R7");
    abort_next = 1'b1;
    push_wr(22'h280, 4'b0001, 32'h00000066);
    dev_xfer(1, 0, 24'h000A00, 16'h0066, 1, 0, 0, "R7");
    drain("R7");
    push_wr(22'h281, 4'b0001, 32'h00000077);
    dev_xfer(1, 0, 24'h000A04, 16'h0077, 1, 0, 0, "R7");
    drain("R7");

    // R12 pacing
    pacer_phase(3'b110, 12, 1, 4);
    pacer_phase(3'b000, 6, 0, 0);
    pacer_phase(3'b100, 9, 2, 3);
    pacer_phase(3'b000, 4, 0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule